// File: doc/BRIEF.md
# Precise Exception Tracking Controller

This controller runs beside a five-stage in-order pipeline and makes every exception precise. A stage that detects a problem does not act on it. It raises a strobe, and the controller records a cause code in a small status record. That record moves down the pipe with the instruction. Only the first cause an instruction collects is kept.

The decision is made as the instruction passes from MEM into WB. If its record carries a cause, the controller raises a one-cycle trap pulse. In that cycle it blocks the instruction's write-back and squashes the younger instructions in IF, ID, EX and MEM. It also redirects fetch to a fixed trap vector. The faulting PC and the cause code go into a held exception address register. When the faulting instruction sits in a branch delay slot, its next PC is saved as well.

Every instruction older than the faulting one has already left MEM, so it completes normally. The fault taken is therefore always the one that comes first in program order, not the one that was detected first in time.

Top module: `precise_exc_ctrl`

## Requirements
- R1: After synchronous reset, `redirect_o`, `squash_o` and `wb_block_o` are low, and `epc_o`, `enpc_o`, `epc_dslot_o` and `cause_o` are zero.
- R2: Cause codes on `cause_o` are as follows:
  - 1, 2 and 3 are the IF faults (page fault, misaligned fetch, protection violation). They are taken from `if_cause_i` as given.
  - 4 is an illegal or privileged instruction, from `raise_i[0]` (ID).
  - 5 is an arithmetic exception, from `raise_i[1]` (EX).
  - 6 is a data memory fault, from `raise_i[2]` (MEM).
  - 0 means no cause, and 7 is never reported.
- R3: With `adv_i` high every cycle, an instruction fetched with a fault in cycle t raises `redirect_o`, `squash_o` and `wb_block_o` in cycle t+4. These stay high for exactly one cycle. `redirect_pc_o` always equals the TRAP_VEC parameter.
- R4: When one instruction collects several causes, the cause from the earliest stage is reported (IF before ID before EX before MEM).
- R5: If an older instruction in MEM faults in the same cycle that a younger instruction faults in IF, the older instruction's cause and PC are taken.
- R6: Instructions that are in ID, EX or MEM when a trap is taken never cause a later trap, and neither does the instruction in IF during the trap cycle. The saved cause and PC stay those of the faulting instruction.
- R7: On a trap, `epc_o` takes the faulting instruction's PC. If that instruction was fetched with `if_dslot_i` high, then `enpc_o` takes its next PC and `epc_dslot_o` is 1; otherwise both are 0. These values hold until the next trap.
- R8: While `adv_i` is low, no trap is taken and the records hold. A strobe raised during a stall is still posted, and the trap follows on the first cycle in which `adv_i` is high.
- R9: A strobe raised for a stage that holds a bubble is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_i | input | 1 | Pipeline advances at this edge |
| if_valid_i | input | 1 | IF holds a valid instruction |
| if_pc_i | input | PC_W | PC of the IF instruction |
| if_next_pc_i | input | PC_W | Next PC in program order of the IF instruction |
| if_dslot_i | input | 1 | IF instruction sits in a delay slot |
| if_cause_i | input | 2 | IF fault: 0 none, 1 page, 2 misaligned, 3 protection |
| raise_i | input | 3 | Cause strobes: bit0 ID, bit1 EX, bit2 MEM |
| squash_o | output | 1 | Turn IF, ID, EX and MEM into bubbles |
| wb_block_o | output | 1 | Block state writes of the WB instruction |
| redirect_o | output | 1 | Force the trap fetch into IF |
| redirect_pc_o | output | PC_W | Trap fetch address |
| epc_o | output | PC_W | Saved faulting PC |
| enpc_o | output | PC_W | Saved next PC for delay-slot faults |
| epc_dslot_o | output | 1 | Saved fault was in a delay slot |
| cause_o | output | 3 | Saved cause code |

## Verification
The trap pulse appears one clock after the edge at which the flagged instruction leaves MEM with `adv_i` high. For faults raised in IF, ID, EX or MEM this is 4, 3, 2 or 1 advancing edges after the strobe cycle. A stall pushes the pulse back by one cycle for every cycle `adv_i` is low.

The bench drives inputs on the falling edge and steps a cycle-level reference model to get the values due after the next rising edge. It samples the outputs at the falling edge after that, so every comparison lands one edge after its stimulus. The directed cases count their advancing edges by hand to place the expected pulse and saved fields.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int TRACK_STAGES = 3;
  localparam int CAUSE_W      = 3;

  typedef enum logic [CAUSE_W-1:0] {
    EXC_NONE     = 3'd0,
    EXC_IF_PAGE  = 3'd1,
    EXC_IF_ALIGN = 3'd2,
    EXC_IF_PROT  = 3'd3,
    EXC_ID_INSN  = 3'd4,
    EXC_EX_ARITH = 3'd5,
    EXC_MEM_DATA = 3'd6
  } exc_code_e;

  // code posted by tracked stage k (0 = ID, 1 = EX, 2 = MEM)
  function automatic exc_code_e stage_code(int k);
    case (k)
      0:       return EXC_ID_INSN;
      1:       return EXC_EX_ARITH;
      default: return EXC_MEM_DATA;
    endcase
  endfunction

endpackage

// File: rtl/exc_track_stage.sv
module exc_track_stage #(
  parameter int PC_W = 32,
  parameter exc_pkg::exc_code_e RAISE_CODE = exc_pkg::EXC_ID_INSN
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                adv_i,
  input  logic                kill_i,
  input  logic                raise_i,
  input  logic                in_v,
  input  logic                in_ds,
  input  logic [PC_W-1:0]     in_pc,
  input  logic [PC_W-1:0]     in_npc,
  input  exc_pkg::exc_code_e  in_cause,
  output logic                out_v,
  output logic                out_ds,
  output logic [PC_W-1:0]     out_pc,
  output logic [PC_W-1:0]     out_npc,
  output exc_pkg::exc_code_e  out_cause
);
  import exc_pkg::*;

  logic            v_q, ds_q;
  logic [PC_W-1:0] pc_q, npc_q;
  exc_code_e       cause_q, merged;

  // first cause wins; bubbles never take a cause
  always_comb begin
    merged = cause_q;
    if (v_q && cause_q == EXC_NONE && raise_i) merged = RAISE_CODE;
  end

  always_ff @(posedge clk) begin
    if (rst || kill_i) begin
      v_q     <= 1'b0;
      ds_q    <= 1'b0;
      pc_q    <= '0;
      npc_q   <= '0;
      cause_q <= EXC_NONE;
    end else if (adv_i) begin
      v_q     <= in_v;
      ds_q    <= in_ds;
      pc_q    <= in_pc;
      npc_q   <= in_npc;
      cause_q <= in_cause;
    end else begin
      cause_q <= merged;
    end
  end

  assign out_v     = v_q;
  assign out_ds    = ds_q;
  assign out_pc    = pc_q;
  assign out_npc   = npc_q;
  assign out_cause = merged;

  // R6
  kill_clears_chk: assert property (@(posedge clk) disable iff (rst)
    $past(kill_i) |-> !v_q);
  // R9
  bubble_clean_chk: assert property (@(posedge clk) disable iff (rst)
    !v_q |-> cause_q == EXC_NONE);
  // R4
  cause_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (!adv_i && !kill_i && v_q && cause_q != EXC_NONE) |=> cause_q == $past(cause_q));

endmodule

// File: rtl/exc_commit.sv
module exc_commit #(
  parameter int PC_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                adv_i,
  input  logic                head_v,
  input  logic                head_ds,
  input  logic [PC_W-1:0]     head_pc,
  input  logic [PC_W-1:0]     head_npc,
  input  exc_pkg::exc_code_e  head_cause,
  output logic                kill_o,
  output logic                trap_o,
  output logic [PC_W-1:0]     epc_o,
  output logic [PC_W-1:0]     enpc_o,
  output logic                slot_o,
  output exc_pkg::exc_code_e  cause_o
);
  import exc_pkg::*;

  logic            fire, trap_q, slot_q;
  logic [PC_W-1:0] epc_q, enpc_q;
  exc_code_e       cause_q;

  // decision at WB entry
  assign fire   = adv_i && head_v && head_cause != EXC_NONE && !trap_q;
  assign kill_o = fire || trap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_q  <= 1'b0;
      epc_q   <= '0;
      enpc_q  <= '0;
      slot_q  <= 1'b0;
      cause_q <= EXC_NONE;
    end else begin
      trap_q <= fire;
      if (fire) begin
        epc_q   <= head_pc;
        enpc_q  <= head_ds ? head_npc : '0;
        slot_q  <= head_ds;
        cause_q <= head_cause;
      end
    end
  end

  assign trap_o  = trap_q;
  assign epc_o   = epc_q;
  assign enpc_o  = enpc_q;
  assign slot_o  = slot_q;
  assign cause_o = cause_q;

  // R3
  trap_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    trap_q |=> !trap_q);
  // R8
  trap_needs_adv_chk: assert property (@(posedge clk) disable iff (rst)
    trap_q |-> $past(adv_i));
  // R2
  cause_legal_chk: assert property (@(posedge clk) disable iff (rst)
    trap_q |-> (cause_q != EXC_NONE && cause_q <= EXC_MEM_DATA));
  // R7
  slot_npc_chk: assert property (@(posedge clk) disable iff (rst)
    (trap_q && !slot_q) |-> enpc_q == '0);

endmodule

// File: rtl/precise_exc_ctrl.sv
module precise_exc_ctrl #(
  parameter int              PC_W     = 32,
  parameter logic [PC_W-1:0] TRAP_VEC = 32'h0000_0080
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            adv_i,
  input  logic            if_valid_i,
  input  logic [PC_W-1:0] if_pc_i,
  input  logic [PC_W-1:0] if_next_pc_i,
  input  logic            if_dslot_i,
  input  logic [1:0]      if_cause_i,
  input  logic [2:0]      raise_i,
  output logic            squash_o,
  output logic            wb_block_o,
  output logic            redirect_o,
  output logic [PC_W-1:0] redirect_pc_o,
  output logic [PC_W-1:0] epc_o,
  output logic [PC_W-1:0] enpc_o,
  output logic            epc_dslot_o,
  output logic [2:0]      cause_o
);
  import exc_pkg::*;

  localparam int TS = TRACK_STAGES;

  // index 0 = record entering ID, index k+1 = record leaving tracked stage k
  logic            rv  [0:TS];
  logic            rds [0:TS];
  logic [PC_W-1:0] rpc [0:TS];
  logic [PC_W-1:0] rnpc[0:TS];
  exc_code_e       rc  [0:TS];
  logic            kill, trap;
  exc_code_e       saved_cause;

  assign rv[0]   = if_valid_i;
  assign rds[0]  = if_dslot_i;
  assign rpc[0]  = if_pc_i;
  assign rnpc[0] = if_next_pc_i;
  assign rc[0]   = if_valid_i ? exc_code_e'({1'b0, if_cause_i}) : EXC_NONE;

  for (genvar k = 0; k < TS; k++) begin : g_stage
    exc_track_stage #(
      .PC_W(PC_W),
      .RAISE_CODE(stage_code(k))
    ) u_stage (
      .clk(clk), .rst(rst), .adv_i(adv_i), .kill_i(kill), .raise_i(raise_i[k]),
      .in_v(rv[k]), .in_ds(rds[k]), .in_pc(rpc[k]), .in_npc(rnpc[k]), .in_cause(rc[k]),
      .out_v(rv[k+1]), .out_ds(rds[k+1]), .out_pc(rpc[k+1]), .out_npc(rnpc[k+1]),
      .out_cause(rc[k+1])
    );
  end

  exc_commit #(.PC_W(PC_W)) u_commit (
    .clk(clk), .rst(rst), .adv_i(adv_i),
    .head_v(rv[TS]), .head_ds(rds[TS]), .head_pc(rpc[TS]), .head_npc(rnpc[TS]),
    .head_cause(rc[TS]),
    .kill_o(kill), .trap_o(trap), .epc_o(epc_o), .enpc_o(enpc_o),
    .slot_o(epc_dslot_o), .cause_o(saved_cause)
  );

  assign squash_o      = trap;
  assign wb_block_o    = trap;
  assign redirect_o    = trap;
  assign redirect_pc_o = TRAP_VEC;
  assign cause_o       = saved_cause;

endmodule

// File: tb/sim_precise_exc_ctrl.sv
module sim_precise_exc_ctrl;
  localparam logic [31:0] TV = 32'h0000_0080;

  logic clk = 1'b0, rst = 1'b1;
  logic adv_i = 0, if_valid_i = 0, if_dslot_i = 0;
  logic [31:0] if_pc_i = 0, if_next_pc_i = 0;
  logic [1:0] if_cause_i = 0;
  logic [2:0] raise_i = 0;
  logic squash_o, wb_block_o, redirect_o, epc_dslot_o;
  logic [31:0] redirect_pc_o, epc_o, enpc_o;
  logic [2:0] cause_o;

  always #5 clk = ~clk;

  precise_exc_ctrl #(.PC_W(32), .TRAP_VEC(TV)) u0 (
    .clk(clk), .rst(rst), .adv_i(adv_i), .if_valid_i(if_valid_i), .if_pc_i(if_pc_i),
    .if_next_pc_i(if_next_pc_i), .if_dslot_i(if_dslot_i), .if_cause_i(if_cause_i),
    .raise_i(raise_i), .squash_o(squash_o), .wb_block_o(wb_block_o),
    .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o), .epc_o(epc_o),
    .enpc_o(enpc_o), .epc_dslot_o(epc_dslot_o), .cause_o(cause_o));

  int tests = 0, fails = 0;
  bit done = 0;

  // reference model: ID, EX, MEM records plus saved trap state
  bit mv[3]; bit mds[3]; logic [31:0] mpc[3], mnpc[3]; int mc[3];
  bit mtrap = 0, mslot = 0; logic [31:0] mepc = 0, menpc = 0; int mcause = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int code_of(int k);
    return 4 + k;
  endfunction

  task automatic model_step(bit adv, bit ifv, logic [31:0] pc, logic [31:0] npc,
                            bit ds, logic [1:0] ic, logic [2:0] rs);
    int mg[3];
    bit fire;
    for (int k = 0; k < 3; k++)
      mg[k] = (mv[k] && mc[k] == 0 && rs[k]) ? code_of(k) : mc[k];
    fire = adv && mv[2] && mg[2] != 0 && !mtrap;
    if (fire || mtrap) begin
      if (fire) begin
        mepc = mpc[2]; menpc = mds[2] ? mnpc[2] : 0; mslot = mds[2]; mcause = mg[2];
      end
      mtrap = fire;
      for (int k = 0; k < 3; k++) begin mv[k] = 0; mc[k] = 0; mds[k] = 0; end
    end else if (adv) begin
      for (int k = 2; k > 0; k--) begin
        mv[k] = mv[k-1]; mds[k] = mds[k-1]; mpc[k] = mpc[k-1];
        mnpc[k] = mnpc[k-1]; mc[k] = mg[k-1];
      end
      mv[0] = ifv; mds[0] = ds; mpc[0] = pc; mnpc[0] = npc; mc[0] = ifv ? int'(ic) : 0;
    end else begin
      for (int k = 0; k < 3; k++) mc[k] = mg[k];
    end
  endtask

  task automatic cyc(bit adv, bit ifv, logic [31:0] pc, logic [31:0] npc,
                     bit ds, logic [1:0] ic, logic [2:0] rs);
    adv_i = adv; if_valid_i = ifv; if_pc_i = pc; if_next_pc_i = npc;
    if_dslot_i = ds; if_cause_i = ic; raise_i = rs;
    model_step(adv, ifv, pc, npc, ds, ic, rs);
    @(negedge clk);
    chk("R3 redirect", 64'(redirect_o), 64'(mtrap));
    chk("R6 squash", 64'(squash_o), 64'(mtrap));
    chk("R6 wb_block", 64'(wb_block_o), 64'(mtrap));
    chk("R3 trap vector", 64'(redirect_pc_o), 64'(TV));
    chk("R7 epc", 64'(epc_o), 64'(mepc));
    chk("R7 enpc", 64'(enpc_o), 64'(menpc));
    chk("R7 dslot", 64'(epc_dslot_o), 64'(mslot));
    chk("R2 cause", 64'(cause_o), 64'(mcause));
  endtask

  task automatic bub(int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int seen;
    logic [31:0] rpc;
    void'($urandom(32'd4242));
    for (int k = 0; k < 3; k++) begin mv[k] = 0; mds[k] = 0; mpc[k] = 0; mnpc[k] = 0; mc[k] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1 reset state
    chk("R1 redirect", 64'(redirect_o), 0);
    chk("R1 squash", 64'(squash_o), 0);
    chk("R1 wb_block", 64'(wb_block_o), 0);
    chk("R1 epc", 64'(epc_o), 0);
    chk("R1 enpc", 64'(enpc_o), 0);
    chk("R1 dslot", 64'(epc_dslot_o), 0);
    chk("R1 cause", 64'(cause_o), 0);

    // R2/R3: misaligned fetch, trap four advancing edges later
    cyc(1, 1, 32'h100, 32'h104, 0, 2'd2, 0);
    bub(2);
    chk("R3 no early trap", 64'(redirect_o), 0);
    bub(1);
    chk("R3 trap at t+4", 64'(redirect_o), 1);
    chk("R2 IF misaligned code", 64'(cause_o), 2);
    chk("R7 epc plain", 64'(epc_o), 32'h100);
    chk("R7 no slot", 64'(epc_dslot_o), 0);
    bub(1);
    chk("R3 one-cycle pulse", 64'(redirect_o), 0);

    // R5/R6: older MEM fault vs younger IF fault in the same cycle
    cyc(1, 1, 32'h200, 32'h204, 0, 0, 0);
    cyc(1, 1, 32'h204, 32'h208, 0, 0, 0);
    cyc(1, 1, 32'h208, 32'h20c, 0, 0, 0);
    cyc(1, 1, 32'h20c, 32'h210, 0, 2'd1, 3'b100);
    chk("R5 older fault taken", 64'(redirect_o), 1);
    chk("R5 cause MEM", 64'(cause_o), 6);
    chk("R5 epc older", 64'(epc_o), 32'h200);
    seen = 0;
    for (int i = 0; i < 6; i++) begin
      cyc(1, 1, 32'h80 + 32'(4 * i), 32'h84 + 32'(4 * i), 0, 0, 0);
      if (redirect_o) seen++;
    end
    chk("R6 squashed fault never taken", 64'(seen), 0);
    chk("R6 saved cause kept", 64'(cause_o), 6);
    chk("R6 saved epc kept", 64'(epc_o), 32'h200);

    // R4: IF cause beats later ID/EX/MEM strobes on the same instruction
    cyc(1, 1, 32'h300, 32'h304, 0, 2'd3, 0);
    cyc(1, 0, 0, 0, 0, 0, 3'b001);
    cyc(1, 0, 0, 0, 0, 0, 3'b010);
    cyc(1, 0, 0, 0, 0, 0, 3'b100);
    chk("R4 IF cause kept", 64'(cause_o), 3);
    bub(1);
    // R4: ID cause beats EX and MEM
    cyc(1, 1, 32'h310, 32'h314, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0, 3'b001);
    cyc(1, 0, 0, 0, 0, 0, 3'b010);
    cyc(1, 0, 0, 0, 0, 0, 3'b100);
    chk("R4 ID cause kept", 64'(cause_o), 4);
    bub(1);

    // R7: delay-slot fault saves next PC
    cyc(1, 1, 32'h340, 32'h400, 1, 0, 0);
    cyc(1, 0, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0, 3'b010);
    cyc(1, 0, 0, 0, 0, 0, 0);
    chk("R7 slot trap", 64'(redirect_o), 1);
    chk("R2 EX code", 64'(cause_o), 5);
    chk("R7 slot epc", 64'(epc_o), 32'h340);
    chk("R7 slot enpc", 64'(enpc_o), 32'h400);
    chk("R7 slot flag", 64'(epc_dslot_o), 1);
    bub(1);

    // R8: fault posted during a stall, taken when the pipe advances
    cyc(1, 1, 32'h500, 32'h504, 0, 0, 0);
    bub(2);
    cyc(0, 0, 0, 0, 0, 0, 3'b100);
    chk("R8 no trap in stall", 64'(redirect_o), 0);
    cyc(0, 0, 0, 0, 0, 0, 0);
    chk("R8 still stalled", 64'(redirect_o), 0);
    cyc(1, 0, 0, 0, 0, 0, 0);
    chk("R8 trap after stall", 64'(redirect_o), 1);
    chk("R8 posted cause", 64'(cause_o), 6);
    chk("R8 epc", 64'(epc_o), 32'h500);
    bub(1);

    // R9: strobes against bubbles are ignored
    seen = 0;
    for (int i = 0; i < 4; i++) begin cyc(1, 0, 0, 0, 0, 0, 3'b111); if (redirect_o) seen++; end
    cyc(1, 1, 32'h600, 32'h604, 0, 0, 0);
    for (int i = 0; i < 4; i++) begin cyc(1, 0, 0, 0, 0, 0, 0); if (redirect_o) seen++; end
    chk("R9 bubble strobes ignored", 64'(seen), 0);
    chk("R9 saved epc unchanged", 64'(epc_o), 32'h500);

    // constrained random against the model
    rpc = 32'h1000;
    for (int i = 0; i < 3000; i++) begin
      bit a, v, d;
      logic [1:0] ic;
      logic [2:0] rs;
      a = ($urandom % 5) != 0;
      v = ($urandom % 4) != 0;
      d = ($urandom % 6) == 0;
      ic = (($urandom % 12) == 0) ? 2'(1 + $urandom % 3) : 2'd0;
      rs = {($urandom % 14) == 0, ($urandom % 14) == 0, ($urandom % 14) == 0};
      cyc(a, v, rpc, d ? rpc + 32'h40 : rpc + 4, d, ic, rs);
      if (a && v) rpc += 4;
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule